// File: doc/BRIEF.md
# Floating-Point Condition Flags and Predicate Evaluator

This block classifies an 80-bit extended-precision value (a 16-bit word holding the sign and a 15-bit biased exponent, followed by a 64-bit mantissa with an explicit integer bit) into four condition flags: negative, zero, infinity and not-a-number. The flags are captured into a status word on any clock edge where the update strobe is high. They are held at all other times.

A combinational path reads the held flags and a 6-bit condition selector and returns whether the chosen predicate is true. The same result drives a set-on-condition path. That path takes a 32-bit data register value and returns it with its low byte replaced by all ones (predicate true) or all zeros (predicate false). The upper 24 bits are passed through untouched.

A floating-point execution unit uses it by strobing each new result in. Conditional branch, set and trap logic then query the predicate with the selector taken from the instruction.

Top module: `fpcc_unit`

## Requirements
- R1: The flags change only on a rising clock edge where `upd_valid` is 1. At that edge all four are re-evaluated from `op_sign_exp`/`op_mant`. With `upd_valid` at 0 they hold, whatever the operand inputs do.
- R2: The negative flag equals the sign bit, `op_sign_exp[15]`.
- R3: The zero flag is set when the exponent `op_sign_exp[14:0]` is 0 and the fraction `op_mant[62:0]` is 0. The integer bit `op_mant[63]` is ignored.
- R4: The infinity flag is set when the exponent is 0x7FFF and `op_mant[62:0]` is 0. The integer bit is ignored.
- R5: The not-a-number flag is set when the exponent is 0x7FFF and `op_mant[62:0]` is nonzero. At most one of zero, infinity and not-a-number is set.
- R6: `status_cc` holds the flags at fixed positions: bit 27 negative, bit 26 zero, bit 25 infinity, bit 24 not-a-number. Every other bit is 0.
- R7: Selector bit 4 is ignored. Selectors 0x10 to 0x1F give the same result as 0x00 to 0x0F.
- R8: Code 0x0 is always false and code 0xF is always true.
- R9: Codes 0x1 to 0x5 use these expressions, where NaN, Z and N are the flags above: 0x1 is Z; 0x2 is NOT(NaN OR Z OR N); 0x3 is Z OR NOT(NaN OR N); 0x4 is N AND NOT(NaN OR Z); 0x5 is Z OR (N AND NOT NaN).
- R10: Codes 0x6 to 0xE use these expressions: 0x6 is NOT NaN AND NOT Z; 0x7 is NOT NaN; 0x8 is NaN; 0x9 is NaN OR Z; 0xA is NaN OR NOT(N OR Z); 0xB is NaN OR Z OR NOT N; 0xC is NaN OR (N AND NOT Z); 0xD is NaN OR Z OR N; 0xE is NOT Z.
- R11: A selector of 0x20 to 0x3F raises `cond_illegal` and forces `cond_true` to 0. Otherwise `cond_illegal` is 0.
- R12: `dreg_out[7:0]` is 0xFF when `cond_true` is 1 and 0x00 when it is 0. `dreg_out[31:8]` equals `dreg_in[31:8]`.
- R13: Reset is asynchronous and active low, and its release takes effect on a clock edge. While in reset, and after it until the first update, all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Capture flags from the operand on this edge |
| op_sign_exp | input | 16 | Sign bit and 15-bit biased exponent of the operand |
| op_mant | input | 64 | Mantissa with explicit integer bit in bit 63 |
| cond_sel | input | 6 | Condition selector |
| dreg_in | input | 32 | Data register value for set-on-condition |
| status_cc | output | 32 | Status word with the flags in bits 27..24 |
| cond_true | output | 1 | Predicate result |
| cond_illegal | output | 1 | Selector outside the legal range |
| dreg_out | output | 32 | Data register value with the low byte set by the predicate |

## Verification
The assertions check, on every cycle, the relations that hold whatever the operand or selector:
- flags hold without a strobe;
- the sign is captured on a strobe;
- zero, infinity and not-a-number never coexist;
- an illegal selector never yields true;
- code 0xF is always true;
- the low byte of the data output follows the predicate while the upper bits pass through.

Only the bench's scenarios can show the following:
- that each selector code matches its expression for each class of operand (signed zeros, infinities, NaNs with and without the integer bit, pseudo-infinities and denormals);
- that the upper selector half mirrors the lower half;
- that the flags sit at the right status bit positions.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  // Flag order matches the status bit order, highest first.
  typedef struct packed {
    logic neg;
    logic zero;
    logic inf;
    logic nan;
  } fpcc_flags_t;

  localparam int CC_LSB  = 24;
  localparam int CC_BITS = 4;
  localparam int CODE_W  = 4;

  typedef enum logic [CODE_W-1:0] {
    PR_NEVER  = 4'h0, PR_EQ   = 4'h1, PR_GT   = 4'h2, PR_GE   = 4'h3,
    PR_LT     = 4'h4, PR_LE   = 4'h5, PR_LG   = 4'h6, PR_ORD  = 4'h7,
    PR_UNORD  = 4'h8, PR_UEQ  = 4'h9, PR_UGT  = 4'hA, PR_UGE  = 4'hB,
    PR_ULT    = 4'hC, PR_ULE  = 4'hD, PR_NE   = 4'hE, PR_ALWAYS = 4'hF
  } fpcc_pred_e;
endpackage

// File: rtl/fpcc_rst_sync.sv
module fpcc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/fpcc_classify.sv
module fpcc_classify
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int MANT_W = 64
) (
  input  logic [EXP_W:0]    sign_exp,
  input  logic [MANT_W-1:0] mant,
  output fpcc_flags_t       cls
);
  localparam int FRAC_W = MANT_W - 1;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_min;
  logic              exp_max;
  logic              frac_nz;
  logic              unused_int_bit;

  assign exp_f          = sign_exp[EXP_W-1:0];
  assign frac_f         = mant[FRAC_W-1:0];
  assign unused_int_bit = mant[MANT_W-1];  // explicit integer bit plays no part

  always_comb begin
    exp_min  = (exp_f == '0);
    exp_max  = (exp_f == '1);
    frac_nz  = |frac_f;
    cls.neg  = sign_exp[EXP_W];
    cls.zero = exp_min & ~frac_nz;
    cls.inf  = exp_max & ~frac_nz;
    cls.nan  = exp_max &  frac_nz;
  end
endmodule

// File: rtl/fpcc_flag_reg.sv
module fpcc_flag_reg
  import fpcc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        upd,
  input  fpcc_flags_t cls,
  output fpcc_flags_t flags_q
);
  fpcc_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (upd) flags_d = cls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  // R1: no strobe, no change
  a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_q));
  // R2: sign captured on a strobe
  a_r2_sign_captured: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (flags_q.neg == $past(cls.neg)));
  // R5: classes are exclusive
  a_r5_class_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags_q.zero, flags_q.inf, flags_q.nan}));
endmodule

// File: rtl/fpcc_cond_eval.sv
module fpcc_cond_eval
  import fpcc_pkg::*;
#(
  parameter int SEL_W  = 6,
  parameter int DATA_W = 32
) (
  input  fpcc_flags_t       flags,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] din,
  output logic              hit,
  output logic              illegal,
  output logic [DATA_W-1:0] dout
);
  localparam int BYTE_W = 8;

  fpcc_pred_e code;
  logic       raw;
  logic       n, z, u;
  logic       unused_mirror;

  assign code          = fpcc_pred_e'(sel[CODE_W-1:0]);
  assign unused_mirror = sel[CODE_W];       // upper half repeats lower half
  assign illegal       = |sel[SEL_W-1:CODE_W+1];
  assign n             = flags.neg;
  assign z             = flags.zero;
  assign u             = flags.nan;

  always_comb begin
    unique case (code)
      PR_NEVER:  raw = 1'b0;
      PR_EQ:     raw = z;
      PR_GT:     raw = ~(u | z | n);
      PR_GE:     raw = z | ~(u | n);
      PR_LT:     raw = n & ~(u | z);
      PR_LE:     raw = z | (n & ~u);
      PR_LG:     raw = ~u & ~z;
      PR_ORD:    raw = ~u;
      PR_UNORD:  raw = u;
      PR_UEQ:    raw = u | z;
      PR_UGT:    raw = u | ~(n | z);
      PR_UGE:    raw = u | z | ~n;
      PR_ULT:    raw = u | (n & ~z);
      PR_ULE:    raw = u | z | n;
      PR_NE:     raw = ~z;
      PR_ALWAYS: raw = 1'b1;
      default:   raw = 1'b0;
    endcase
  end

  assign hit  = raw & ~illegal;
  assign dout = {din[DATA_W-1:BYTE_W], {BYTE_W{hit}}};
endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
  import fpcc_pkg::*;
#(
  parameter int EXP_W       = 15,
  parameter int MANT_W      = 64,
  parameter int SEL_W       = 6,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [EXP_W:0]    op_sign_exp,
  input  logic [MANT_W-1:0] op_mant,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [DATA_W-1:0] dreg_in,
  output logic [DATA_W-1:0] status_cc,
  output logic              cond_true,
  output logic              cond_illegal,
  output logic [DATA_W-1:0] dreg_out
);
  localparam int BYTE_W = 8;

  logic        rst_sync_n;
  fpcc_flags_t cls;
  fpcc_flags_t flags_q;

  fpcc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  fpcc_classify #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_cls (
    .sign_exp(op_sign_exp), .mant(op_mant), .cls(cls));

  fpcc_flag_reg u_flags (
    .clk(clk), .rst_n(rst_sync_n), .upd(upd_valid),
    .cls(cls), .flags_q(flags_q));

  fpcc_cond_eval #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_eval (
    .flags(flags_q), .sel(cond_sel), .din(dreg_in),
    .hit(cond_true), .illegal(cond_illegal), .dout(dreg_out));

  always_comb begin
    status_cc = '0;
    status_cc[CC_LSB +: CC_BITS] = flags_q;
  end

  // R11: illegal selector never reports true
  a_r11_illegal_false: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cond_illegal |-> !cond_true);
  // R8: legal code 0xF always true
  a_r8_always_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cond_illegal && cond_sel[CODE_W-1:0] == '1) |-> cond_true);
  // R12: low byte follows predicate
  a_r12_low_byte: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dreg_out[BYTE_W-1:0] == {BYTE_W{cond_true}});
  // R12: upper part passes through
  a_r12_upper_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dreg_out[DATA_W-1:BYTE_W] == dreg_in[DATA_W-1:BYTE_W]);
endmodule

// File: tb/sim_fpcc_unit.sv
module sim_fpcc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic [15:0] op_sign_exp = '0;
  logic [63:0] op_mant = '0;
  logic [5:0]  cond_sel = '0;
  logic [31:0] dreg_in = '0;
  logic [31:0] status_cc;
  logic        cond_true;
  logic        cond_illegal;
  logic [31:0] dreg_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  fpcc_unit u0 (.*);

  typedef struct {
    logic [3:0]  flg;     // {N,Z,I,NaN}
    logic        loaded;
    logic        from_reset;
    logic [5:0]  sel;
    logic        exp_true;
    logic        exp_ill;
    logic [31:0] exp_dout;
  } item_t;

  item_t q[$];
  logic [3:0] mdl_flags = '0;

  function automatic logic [3:0] ref_flags(input logic [15:0] se, input logic [63:0] m);
    logic ez, emax, fz;
    ez   = (se[14:0] == 15'h0000);
    emax = (se[14:0] == 15'h7FFF);
    fz   = (m[62:0] == 63'd0);
    return {se[15], ez && fz, emax && fz, emax && !fz};
  endfunction

  // Relation-class model: unordered, equal, less, greater.
  function automatic logic ref_pred(input logic [3:0] f, input logic [5:0] s);
    logic uo, eq, lt, gt;
    logic [3:0] m;
    if (s[5]) return 1'b0;
    uo = f[0];
    eq = f[2] && !uo;
    lt = f[3] && !f[2] && !uo;
    gt = !f[3] && !f[2] && !uo;
    case (s[3:0])
      4'h0: m = 4'b0000; 4'h1: m = 4'b0100; 4'h2: m = 4'b0001; 4'h3: m = 4'b0101;
      4'h4: m = 4'b0010; 4'h5: m = 4'b0110; 4'h6: m = 4'b0011; 4'h7: m = 4'b0111;
      4'h8: m = 4'b1000; 4'h9: m = 4'b1100; 4'hA: m = 4'b1001; 4'hB: m = 4'b1101;
      4'hC: m = 4'b1010; 4'hD: m = 4'b1110; 4'hE: m = 4'b1011; default: m = 4'b1111;
    endcase
    return (m[3] && uo) || (m[2] && eq) || (m[1] && lt) || (m[0] && gt);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic upd, input logic [15:0] se, input logic [63:0] m,
                       input logic [5:0] s, input logic [31:0] d, input logic rst_chk);
    item_t it;
    @(negedge clk);
    upd_valid = upd; op_sign_exp = se; op_mant = m; cond_sel = s; dreg_in = d;
    if (upd) mdl_flags = ref_flags(se, m);
    it.flg        = mdl_flags;
    it.loaded     = upd;
    it.from_reset = rst_chk;
    it.sel        = s;
    it.exp_true   = ref_pred(mdl_flags, s);
    it.exp_ill    = s[5];
    it.exp_dout   = {d[31:8], {8{it.exp_true}}};
    q.push_back(it);
  endtask

  // Monitor: results settle after the capturing edge, before the next drive.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        string ptag;
        it = q.pop_front();
        if (it.from_reset) begin
          check("R13 flags after reset release", status_cc, 32'h0);
        end else if (it.loaded) begin
          check("R2 negative flag", {31'd0, status_cc[27]}, {31'd0, it.flg[3]});
          check("R3 zero flag",     {31'd0, status_cc[26]}, {31'd0, it.flg[2]});
          check("R4 infinity flag", {31'd0, status_cc[25]}, {31'd0, it.flg[1]});
          check("R5 nan flag",      {31'd0, status_cc[24]}, {31'd0, it.flg[0]});
          check("R6 other status bits", status_cc & 32'hF0FF_FFFF, 32'h0);
        end else begin
          check("R1 held flags", status_cc, {4'h0, it.flg, 24'h0});
        end
        if (it.sel[5])                                 ptag = "R11 illegal selector result";
        else if (it.sel[4])                            ptag = "R7 mirrored selector";
        else if (it.sel[3:0] == 4'h0 || it.sel[3:0] == 4'hF) ptag = "R8 constant code";
        else if (it.sel[3:0] <= 4'h5)                  ptag = "R9 ordered code";
        else                                           ptag = "R10 code";
        check($sformatf("%s sel=%h", ptag, it.sel), {31'd0, cond_true}, {31'd0, it.exp_true});
        check("R11 illegal flag", {31'd0, cond_illegal}, {31'd0, it.exp_ill});
        check("R12 set-on-condition output", dreg_out, it.exp_dout);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [79:0] ops [10];
  initial begin
    ops[0] = 80'h3FFF_8000_0000_0000_0000;  // +1.0
    ops[1] = 80'hBFFF_8000_0000_0000_0000;  // -1.0
    ops[2] = 80'h0000_0000_0000_0000_0000;  // +0
    ops[3] = 80'h8000_0000_0000_0000_0000;  // -0
    ops[4] = 80'h7FFF_8000_0000_0000_0000;  // +inf
    ops[5] = 80'hFFFF_0000_0000_0000_0000;  // -inf, integer bit clear
    ops[6] = 80'h7FFF_C000_0000_0000_0000;  // quiet NaN
    ops[7] = 80'hFFFF_0000_0000_0000_0001;  // NaN, low fraction bit only
    ops[8] = 80'h0000_8000_0000_0000_0000;  // exp 0, only integer bit: zero
    ops[9] = 80'h0000_0000_0000_0000_0001;  // denormal, not zero

    // R13: in reset, flags read zero
    drive(1'b0, 16'h0, 64'h0, 6'h0F, 32'h0, 1'b1);
    void'(q.pop_back());
    @(negedge clk); #1;
    check("R13 flags during reset", status_cc, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    drive(1'b0, 16'hBFFF, 64'h8000_0000_0000_0000, 6'h0F, 32'h1234_5600, 1'b1);

    for (int k = 0; k < 10; k++) begin
      drive(1'b1, ops[k][79:64], ops[k][63:0], 6'h01, 32'hA5A5_A5A5 ^ k, 1'b0);
      for (int s = 0; s < 64; s++) begin
        // R1: operand wiggles with no strobe
        drive(1'b0, ~ops[k][79:64], ~ops[k][63:0], 6'(s), 32'hDEAD_BE00 + s * 32'h0101_0101, 1'b0);
      end
    end
    // back-to-back updates
    for (int k = 9; k >= 0; k--)
      drive(1'b1, ops[k][79:64], ops[k][63:0], 6'h12, 32'hFFFF_FF5A, 1'b0);

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule